// File: doc/BRIEF.md
# Sync-Aware Dual-Ratio Clock Divider

This block turns a fast master clock into an auxiliary clock whose period is either four or five master clocks. The choice follows the video timing. In wide pixel mode the short period is used during active video. The long period is used while horizontal sync is asserted. In narrow pixel mode the long period is used all the time. In both ratios the high part of each output period lasts two master clocks, and only the low part grows from two to three. A half-rate dot clock and a one-cycle strobe that marks the start of every output period come from the same counter.

During vertical blanking, the level of horizontal sync no longer selects the ratio. Instead, each rising edge of the active-low horizontal sync input starts a fixed burst of 15 long periods, then 2 short periods, then 15 long periods. After the burst the block stays on the short period. The requested ratio is sampled only when a period ends, so a change on the inputs never makes a truncated or stretched pulse. All inputs pass through one register stage before use.

Top module: `sync_ratio_clkdiv`

## Requirements
- R1: While reset is high, aux_clk is 1, dot_clk is 0 and period_stb is 0. After reset is released, the first period_stb appears on the 4th rising clock edge.
- R2: With narrow=0, vblank=0 and hsync_n=1 held, every output period is 4 master clocks long.
- R3: With narrow=0, vblank=0 and hsync_n=0 held, every output period is 5 master clocks long.
- R4: Every output period starts with aux_clk high for exactly 2 master clocks, followed by a low part of 2 cycles (period 4) or 3 cycles (period 5).
- R5: With narrow=1, every output period is 5 master clocks long, whatever the values of hsync_n and vblank.
- R6: period_stb is high for exactly one master clock, on the first cycle of each output period, and two strobes are never less than 4 master clocks apart.
- R7: dot_clk changes value at every period_stb and at no other time, so its period is two output periods.
- R8: With vblank=1 and narrow=0, a rising edge of hsync_n starts a burst: 15 periods of 5, then 2 periods of 4, then 15 periods of 5, then periods of 4. The first period of 5 begins within two output periods after the edge.
- R9: With vblank=1 and narrow=0, and no burst running, the hsync_n level has no effect: periods stay at 4 while hsync_n is held low.
- R10: A new ratio takes effect only at a period boundary. When hsync_n toggles in the middle of periods, every period is still exactly 4 or 5 cycles long and keeps a 2-cycle high part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync level, low inside the sync region |
| vblank | input | 1 | High during the vertical interval |
| narrow | input | 1 | 1 selects narrow pixel mode (always divide by 5) |
| aux_clk | output | 1 | Divided clock, period 4 or 5 master clocks |
| dot_clk | output | 1 | Half-rate copy of aux_clk |
| period_stb | output | 1 | One-cycle pulse at the start of each aux_clk period |

## Verification
A table of steady mode and sync settings checks that the period length and high width change correctly between wide active video, the horizontal sync region, narrow mode, and a vertical interval with no burst running. This separates the narrow override from the sync-driven selection, and it shows that the sync level is ignored during blanking. A single sync rising edge inside blanking is then traced period by period against the 15/2/15 burst, which catches wrong segment counts or a wrong segment order. Finally, toggling the sync input every three cycles shows whether a ratio change can land in the middle of a period.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Segments of the vertical-interval burst
  typedef enum logic [1:0] {
    SEG_IDLE  = 2'd0,
    SEG_LEAD  = 2'd1,
    SEG_MID   = 2'd2,
    SEG_TRAIL = 2'd3
  } seg_e;

  // Period length in master clocks for a given ratio choice
  function automatic int unsigned div_len(input logic slow,
                                          input int unsigned fast_div,
                                          input int unsigned slow_div);
    return slow ? slow_div : fast_div;
  endfunction

  // Segment that follows the given one when its count runs out
  function automatic seg_e seg_after(input seg_e s);
    case (s)
      SEG_LEAD:  return SEG_MID;
      SEG_MID:   return SEG_TRAIL;
      default:   return SEG_IDLE;
    endcase
  endfunction

  // Number of periods that a segment spans
  function automatic int unsigned seg_count(input seg_e s,
                                            input int unsigned outer_cnt,
                                            input int unsigned mid_cnt);
    case (s)
      SEG_LEAD, SEG_TRAIL: return outer_cnt;
      SEG_MID:             return mid_cnt;
      default:             return 0;
    endcase
  endfunction

  // Whether a segment asks for the long period
  function automatic logic seg_is_slow(input seg_e s);
    return (s == SEG_LEAD) || (s == SEG_TRAIL);
  endfunction

endpackage

// File: rtl/dr_sync_in.sv
module dr_sync_in (
  input  logic clk,
  input  logic rst,
  input  logic hsync_n,
  input  logic vblank,
  input  logic narrow,
  output logic hs_q,
  output logic vb_q,
  output logic nr_q,
  output logic hs_rise
);

  logic hs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b1;
      hs_d <= 1'b1;
      vb_q <= 1'b0;
      nr_q <= 1'b0;
    end else begin
      hs_q <= hsync_n;
      hs_d <= hs_q;
      vb_q <= vblank;
      nr_q <= narrow;
    end
  end

  assign hs_rise = hs_q & ~hs_d;

  // R8: a detected sync edge lasts a single cycle
  a_r8_rise_single: assert property (@(posedge clk) disable iff (rst)
    hs_rise |=> !hs_rise);

endmodule

// File: rtl/dr_vseq.sv
module dr_vseq #(
  parameter int unsigned OUTER_CNT = 15,
  parameter int unsigned MID_CNT   = 2,
  localparam int unsigned MAXC     = (OUTER_CNT > MID_CNT) ? OUTER_CNT : MID_CNT,
  localparam int unsigned CNT_W    = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic load,
  output logic slow_req,
  output logic busy
);
  import dr_pkg::*;

  seg_e             seg;
  seg_e             seg_nx;
  logic [CNT_W-1:0] rem;

  assign seg_nx = seg_after(seg);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg <= SEG_IDLE;
      rem <= '0;
    end else if (start) begin
      seg <= SEG_LEAD;
      rem <= CNT_W'(OUTER_CNT);
    end else if (load && (seg != SEG_IDLE)) begin
      if (rem == CNT_W'(1)) begin
        seg <= seg_nx;
        rem <= CNT_W'(seg_count(seg_nx, OUTER_CNT, MID_CNT));
      end else begin
        rem <= rem - CNT_W'(1);
      end
    end
  end

  assign slow_req = seg_is_slow(seg);
  assign busy     = (seg != SEG_IDLE);

  // R8: a running segment always has periods left to spend
  a_r8_rem_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem != '0));

  // R8: the burst only moves forward on a period boundary or a restart
  a_r8_seg_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !start) |=> $stable(seg));

endmodule

// File: rtl/dr_phase_gen.sv
module dr_phase_gen #(
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned SLOW_DIV = 5,
  parameter int unsigned HIGH_CYC = 2,
  localparam int unsigned PH_W    = $clog2(SLOW_DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_sel,
  output logic aux_clk,
  output logic dot_clk,
  output logic period_stb,
  output logic period_end
);
  import dr_pkg::*;

  localparam logic [PH_W-1:0] FAST_L = PH_W'(FAST_DIV);
  localparam logic [PH_W-1:0] HIGH_L = PH_W'(HIGH_CYC);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_inc;
  logic [PH_W-1:0] len_q;
  logic [PH_W-1:0] len_sel;

  assign ph_inc     = ph + PH_W'(1);
  assign period_end = (ph_inc == len_q);
  assign len_sel    = PH_W'(div_len(slow_sel, FAST_DIV, SLOW_DIV));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= '0;
      len_q      <= FAST_L;
      aux_clk    <= 1'b1;
      dot_clk    <= 1'b0;
      period_stb <= 1'b0;
    end else if (period_end) begin
      ph         <= '0;
      len_q      <= len_sel;
      aux_clk    <= 1'b1;
      dot_clk    <= ~dot_clk;
      period_stb <= 1'b1;
    end else begin
      ph         <= ph_inc;
      aux_clk    <= (ph_inc < HIGH_L);
      period_stb <= 1'b0;
    end
  end

  // R4: high at the first and second cycle of a period, low at the third
  a_r4_high_first: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> aux_clk);
  a_r4_high_second: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> aux_clk);
  a_r4_low_third: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> ##1 !aux_clk);

  // R6: strobes are at least four cycles apart
  a_r6_no_runt: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (!$past(period_stb) && !$past(period_stb, 2) && !$past(period_stb, 3)));

  // R7: dot clock moves with the strobe and only then
  a_r7_dot_toggle: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (dot_clk != $past(dot_clk)));
  a_r7_dot_hold: assert property (@(posedge clk) disable iff (rst)
    !period_stb |-> $stable(dot_clk));

  // R10: the length in use is only replaced at a boundary
  a_r10_len_hold: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(len_q));

endmodule

// File: rtl/sync_ratio_clkdiv.sv
module sync_ratio_clkdiv #(
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned SLOW_DIV  = 5,
  parameter int unsigned HIGH_CYC  = 2,
  parameter int unsigned OUTER_CNT = 15,
  parameter int unsigned MID_CNT   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_n,
  input  logic vblank,
  input  logic narrow,
  output logic aux_clk,
  output logic dot_clk,
  output logic period_stb
);

  logic hs_q;
  logic vb_q;
  logic nr_q;
  logic hs_rise;
  logic burst_start;
  logic burst_slow;
  logic burst_busy;
  logic slow_req;
  logic period_end;

  dr_sync_in u_sync (
    .clk     (clk),
    .rst     (rst),
    .hsync_n (hsync_n),
    .vblank  (vblank),
    .narrow  (narrow),
    .hs_q    (hs_q),
    .vb_q    (vb_q),
    .nr_q    (nr_q),
    .hs_rise (hs_rise)
  );

  assign burst_start = hs_rise & vb_q;

  dr_vseq #(
    .OUTER_CNT (OUTER_CNT),
    .MID_CNT   (MID_CNT)
  ) u_vseq (
    .clk      (clk),
    .rst      (rst),
    .start    (burst_start),
    .load     (period_end),
    .slow_req (burst_slow),
    .busy     (burst_busy)
  );

  // Ratio request: narrow mode wins, then the blanking burst, then sync level
  assign slow_req = nr_q | (vb_q ? burst_slow : ~hs_q);

  dr_phase_gen #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV),
    .HIGH_CYC (HIGH_CYC)
  ) u_phase (
    .clk        (clk),
    .rst        (rst),
    .slow_sel   (slow_req),
    .aux_clk    (aux_clk),
    .dot_clk    (dot_clk),
    .period_stb (period_stb),
    .period_end (period_end)
  );

  // R8: a burst starts the moment a blanking sync edge is seen
  a_r8_burst_begins: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> burst_busy);

  // R9: in blanking with no burst, short periods are requested
  a_r9_idle_fast: assert property (@(posedge clk) disable iff (rst)
    (vb_q && !nr_q && !burst_busy) |-> !slow_req);

endmodule

// File: tb/sync_ratio_clkdiv_bench.sv
module sync_ratio_clkdiv_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_drv = 1'b1;
  logic tog_en = 1'b0;
  logic tog_val = 1'b1;
  logic vblank = 1'b0;
  logic narrow = 1'b0;
  logic hsync_n;
  logic aux_clk, dot_clk, period_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  assign hsync_n = tog_en ? tog_val : hs_drv;

  always #2.5 clk = ~clk;

  sync_ratio_clkdiv u_sync_ratio_clkdiv (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vblank(vblank), .narrow(narrow),
    .aux_clk(aux_clk), .dot_clk(dot_clk), .period_stb(period_stb)
  );

  // Stimulus rows: {narrow, vblank, hsync_n, expected period length}
  localparam int NROW = 9;
  localparam logic [5:0] ROWS [NROW] = '{
    {1'b0, 1'b0, 1'b1, 3'd4},
    {1'b0, 1'b0, 1'b0, 3'd5},
    {1'b1, 1'b0, 1'b0, 3'd5},
    {1'b1, 1'b0, 1'b1, 3'd5},
    {1'b1, 1'b1, 1'b1, 3'd5},
    {1'b1, 1'b1, 1'b0, 3'd5},
    {1'b0, 1'b1, 1'b0, 3'd4},
    {1'b0, 1'b0, 1'b0, 3'd5},
    {1'b0, 1'b0, 1'b1, 3'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one period from a strobe to the next; leaves at the next strobe
  task automatic meas(output int len, output int hi, output int dot);
    while (!period_stb) @(negedge clk);
    len = 0; hi = 0; dot = int'(dot_clk);
    do begin
      if (aux_clk) hi++;
      len++;
      @(negedge clk);
    end while (!period_stb);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (tog_en && (cyc % 3 == 0)) tog_val <= ~tog_val;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int lens [48];
  int len, hi, dot, pdot, n;

  initial begin
    // R1: reset state and first strobe
    repeat (3) @(negedge clk);
    check(aux_clk == 1'b1, "R1 aux_clk in reset", int'(aux_clk), 1);
    check(dot_clk == 1'b0, "R1 dot_clk in reset", int'(dot_clk), 0);
    check(period_stb == 1'b0, "R1 strobe in reset", int'(period_stb), 0);
    rst = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_stb && n < 10);
    check(n == 4, "R1 first strobe edge", n, 4);

    // Table walk: R2, R3, R5, R9 with R4 and R7 on every period
    for (int r = 0; r < NROW; r++) begin
      string tag;
      narrow = ROWS[r][5];
      vblank = ROWS[r][4];
      hs_drv = ROWS[r][3];
      tag = narrow ? "R5" : (vblank ? "R9" : (hs_drv ? "R2" : "R3"));
      repeat (3) meas(len, hi, pdot);
      for (int k = 0; k < 3; k++) begin
        meas(len, hi, dot);
        check(len == int'(ROWS[r][2:0]), tag, len, int'(ROWS[r][2:0]));
        check(hi == 2, "R4 high width", hi, 2);
        check(dot != pdot, "R7 dot toggles", dot, 1 - pdot);
        pdot = dot;
      end
    end

    // R8: burst after a sync rising edge during blanking
    narrow = 1'b0; vblank = 1'b1; hs_drv = 1'b0;
    repeat (4) meas(len, hi, dot);
    check(len == 4, "R9 held low in blanking", len, 4);
    hs_drv = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      meas(len, hi, dot);
      lens[i] = len;
      check(len >= 4, "R6 no short period", len, 4);
    end
    n = 0;
    while (n < 3 && lens[n] != 5) n++;
    check(n <= 2, "R8 burst start latency", n, 2);
    begin
      int bad_a, bad_b, bad_c, bad_d;
      bad_a = 0; bad_b = 0; bad_c = 0; bad_d = 0;
      for (int i = 0; i < 15; i++) if (lens[n + i] != 5) bad_a++;
      for (int i = 15; i < 17; i++) if (lens[n + i] != 4) bad_b++;
      for (int i = 17; i < 32; i++) if (lens[n + i] != 5) bad_c++;
      for (int i = 32; i < 44; i++) if (lens[n + i] != 4) bad_d++;
      check(bad_a == 0, "R8 first 15 long", bad_a, 0);
      check(bad_b == 0, "R8 middle 2 short", bad_b, 0);
      check(bad_c == 0, "R8 second 15 long", bad_c, 0);
      check(bad_d == 0, "R8 short after burst", bad_d, 0);
    end

    // R10: sync toggling mid-period in active video
    vblank = 1'b0;
    repeat (3) meas(len, hi, dot);
    tog_en = 1'b1;
    begin
      int bad_len, bad_hi;
      bad_len = 0; bad_hi = 0;
      for (int i = 0; i < 30; i++) begin
        meas(len, hi, dot);
        if (len != 4 && len != 5) bad_len++;
        if (hi != 2) bad_hi++;
      end
      check(bad_len == 0, "R10 lengths only 4 or 5", bad_len, 0);
      check(bad_hi == 0, "R10 high width kept", bad_hi, 0);
    end
    tog_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule